// File: doc/BRIEF.md
# OLED Panel Bring-Up Command Sequencer

This block produces the byte stream that brings up a page-addressed monochrome OLED controller and later switches it on, switches it off or changes its brightness. A one-cycle `start` pulse first holds the panel's reset pin active for a programmable number of clocks. It then releases the pin and waits the same number of clocks. After that it walks a fixed configuration script. Each step of the script is one command byte or one command argument byte. The arguments come from static configuration inputs. Some of these are packed from small fields and flags, and a few steps are left out depending on those flags.

Every byte goes out on a valid/ready byte port together with a control tag. A serial transport (two-wire or four-wire) sends the tag before the payload. The transport, the supply rails and the frame data sit outside this block. The configuration inputs and `bright_val` are sampled while the block is busy, so they must be held steady from the request until `done`.

Top module: `oled_init_seq`

## Requirements
- R1: On `start`, `panel_rst` is high for exactly RST_CYCLES clocks, then low for exactly RST_CYCLES clocks before the first byte is offered. No byte is offered while `panel_rst` is high.
- R2: Every byte offered carries `tx_ctrl` = 0x80, the command tag.
- R3: With every option enabled, the initialisation bytes are, in order: 0x81, contrast, 0xA1, scan byte, 0xA8, height-1, 0xD3, COM offset, 0xD5, clock byte, 0xD8, mode byte, 0xD9, precharge byte, 0xDA, pins byte, 0xDB, VCOMH, 0x8D, pump byte, 0x91, lookup entries, 0x20, 0x00.
- R4: 0xA1 is left out when segment remap is off. The 0xD8 pair is left out when both area-colour and low-power are off. 0x91 and all lookup entries are left out when the lookup table is disabled. Nothing else shifts.
- R5: Packed arguments: scan byte = 0xC0, with bit 2 set when COM invert is on. Clock byte = oscillator frequency in bits 7:4 and (divide-1) in bits 3:0. Mode byte = 0x1E if area-colour is on, ORed with 0x05 if low-power is on. Precharge byte = phase 2 in bits 7:4 and phase 1 in bits 3:0. Pins byte = 0x02, plus bit 4 when sequential COM is off, plus bit 5 when left/right remap is on. Pump byte = 0x10, plus bit 2 when the pump is needed.
- R6: Lookup entry i is taken from `cfg_lut[8i+7:8i]` and sent in increasing i. An entry below 31 or above 63 is still sent and sets `lut_warn`. `lut_warn` then stays set until the next accepted `start`.
- R7: `disp_on_req` emits the single byte 0xAF and `disp_off_req` emits the single byte 0xAE. Neither pulses `panel_rst`.
- R8: `bright_req` emits 0x81 followed by `bright_val` as captured in the request cycle.
- R9: `busy` rises on an accepted request and falls when the last byte is accepted. `done` is high for exactly one cycle after that. Requests that arrive while busy are ignored. While idle, `tx_valid` is low.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_byte` hold their values.
- R11: When several requests arrive in the same idle cycle, the priority is `start`, then `disp_off_req`, then `disp_on_req`, then `bright_req`. The lower-priority requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run the reset pulse and the initialisation script |
| disp_on_req | input | 1 | Emit the display-on command |
| disp_off_req | input | 1 | Emit the display-off command |
| bright_req | input | 1 | Emit a contrast update |
| bright_val | input | 8 | New contrast value, captured with `bright_req` |
| cfg_contrast | input | 8 | Initial contrast |
| cfg_height | input | 8 | Panel rows |
| cfg_com_offset | input | 8 | Vertical COM offset |
| cfg_clk_div | input | 5 | Display clock divide ratio, 1 to 16 |
| cfg_osc_freq | input | 4 | Oscillator frequency setting |
| cfg_pre1 | input | 4 | Precharge phase 1 |
| cfg_pre2 | input | 4 | Precharge phase 2 |
| cfg_seg_remap | input | 1 | Segment remap enable |
| cfg_com_invert | input | 1 | COM scan direction invert |
| cfg_area_color | input | 1 | Area-colour mode |
| cfg_low_power | input | 1 | Low-power mode |
| cfg_com_seq | input | 1 | Sequential COM pin layout |
| cfg_lr_remap | input | 1 | COM left/right remap |
| cfg_vcomh | input | 8 | VCOMH deselect level |
| cfg_pump_need | input | 1 | Internal charge pump required |
| cfg_lut_en | input | 1 | Send the lookup table |
| cfg_lut | input | 8*LUT_ENTRIES | Lookup entries, entry 0 in the low byte |
| panel_rst | output | 1 | Panel reset pin, high = asserted |
| tx_valid | output | 1 | Byte offered |
| tx_ctrl | output | 8 | Control tag for the byte |
| tx_byte | output | 8 | Payload byte |
| tx_ready | input | 1 | Transport accepts the byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| lut_warn | output | 1 | Sticky out-of-range lookup entry flag |

## Verification
The bench builds the block with RST_CYCLES = 5 and LUT_ENTRIES = 4. The short reset window lets the exact high and low durations of the reset pin be counted clock by clock. Four table entries are enough to include both in-range edges (31 and 63) and one value below the range. The ready line is either held high or driven from a pseudo-random pattern, so bytes stall at many different points in the script, and the same script is checked against expected values under both.

// File: rtl/oled_init_seq.sv
module oled_init_seq #(
  parameter int RST_CYCLES  = 500,
  parameter int LUT_ENTRIES = 4,
  parameter logic [7:0] LUT_LO = 8'd31,
  parameter logic [7:0] LUT_HI = 8'd63
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     disp_on_req,
  input  logic                     disp_off_req,
  input  logic                     bright_req,
  input  logic [7:0]               bright_val,
  input  logic [7:0]               cfg_contrast,
  input  logic [7:0]               cfg_height,
  input  logic [7:0]               cfg_com_offset,
  input  logic [4:0]               cfg_clk_div,
  input  logic [3:0]               cfg_osc_freq,
  input  logic [3:0]               cfg_pre1,
  input  logic [3:0]               cfg_pre2,
  input  logic                     cfg_seg_remap,
  input  logic                     cfg_com_invert,
  input  logic                     cfg_area_color,
  input  logic                     cfg_low_power,
  input  logic                     cfg_com_seq,
  input  logic                     cfg_lr_remap,
  input  logic [7:0]               cfg_vcomh,
  input  logic                     cfg_pump_need,
  input  logic                     cfg_lut_en,
  input  logic [8*LUT_ENTRIES-1:0] cfg_lut,
  output logic                     panel_rst,
  output logic                     tx_valid,
  output logic [7:0]               tx_ctrl,
  output logic [7:0]               tx_byte,
  input  logic                     tx_ready,
  output logic                     busy,
  output logic                     done,
  output logic                     lut_warn
);

  localparam int INIT_LEN = 23 + LUT_ENTRIES;
  localparam int IW = $clog2(INIT_LEN);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam int LW = (LUT_ENTRIES > 1) ? $clog2(LUT_ENTRIES) : 1;
  localparam logic [31:0] LUT_BASE = 32'd21;
  localparam logic [31:0] TAIL0 = 32'(21 + LUT_ENTRIES);
  localparam logic [31:0] TAIL1 = 32'(22 + LUT_ENTRIES);
  localparam logic [7:0] CMD_TAG = 8'h80;

  typedef enum logic [1:0] {M_IDLE, M_RST, M_WAIT, M_RUN} mode_t;
  typedef enum logic [1:0] {K_INIT, K_ON, K_OFF, K_BRIGHT} kind_t;

  mode_t mode;
  kind_t kind;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  logic [7:0] bright_q;
  logic [7:0] lut_arr [LUT_ENTRIES];
  logic [31:0] s;
  logic [LW-1:0] lut_pos;
  logic in_lut, cur_skip, cur_last;
  logic [7:0] cur_byte;
  logic [3:0] div_m1;
  logic [7:0] mode_arg;

  for (genvar i = 0; i < LUT_ENTRIES; i++) begin : g_lut
    assign lut_arr[i] = cfg_lut[8*i +: 8];
  end

  assign s        = 32'(idx);
  assign in_lut   = (s >= LUT_BASE) && (s < TAIL0);
  assign lut_pos  = in_lut ? LW'(s - LUT_BASE) : '0;
  assign div_m1   = 4'(cfg_clk_div - 5'd1);
  assign mode_arg = (cfg_area_color ? 8'h1E : 8'h00) | (cfg_low_power ? 8'h05 : 8'h00);

  always_comb begin
    cur_byte = 8'h00;
    cur_skip = 1'b0;
    cur_last = 1'b0;
    unique case (kind)
      K_ON:  begin cur_byte = 8'hAF; cur_last = 1'b1; end
      K_OFF: begin cur_byte = 8'hAE; cur_last = 1'b1; end
      K_BRIGHT: begin
        cur_byte = (s == 32'd0) ? 8'h81 : bright_q;
        cur_last = (s != 32'd0);
      end
      default: begin
        case (s)
          32'd0:  cur_byte = 8'h81;
          32'd1:  cur_byte = cfg_contrast;
          32'd2:  begin cur_byte = 8'hA1; cur_skip = !cfg_seg_remap; end
          32'd3:  cur_byte = 8'hC0 | {5'b0, cfg_com_invert, 2'b00};
          32'd4:  cur_byte = 8'hA8;
          32'd5:  cur_byte = cfg_height - 8'd1;
          32'd6:  cur_byte = 8'hD3;
          32'd7:  cur_byte = cfg_com_offset;
          32'd8:  cur_byte = 8'hD5;
          32'd9:  cur_byte = {cfg_osc_freq, div_m1};
          32'd10: begin cur_byte = 8'hD8; cur_skip = !(cfg_area_color || cfg_low_power); end
          32'd11: begin cur_byte = mode_arg; cur_skip = !(cfg_area_color || cfg_low_power); end
          32'd12: cur_byte = 8'hD9;
          32'd13: cur_byte = {cfg_pre2, cfg_pre1};
          32'd14: cur_byte = 8'hDA;
          32'd15: cur_byte = {2'b00, cfg_lr_remap, !cfg_com_seq, 4'b0010};
          32'd16: cur_byte = 8'hDB;
          32'd17: cur_byte = cfg_vcomh;
          32'd18: cur_byte = 8'h8D;
          32'd19: cur_byte = {5'b00010, cfg_pump_need, 2'b00};
          32'd20: begin cur_byte = 8'h91; cur_skip = !cfg_lut_en; end
          default: begin
            if (in_lut) begin
              cur_byte = lut_arr[lut_pos];
              cur_skip = !cfg_lut_en;
            end else if (s == TAIL0) begin
              cur_byte = 8'h20;
            end else begin
              cur_byte = 8'h00;
              cur_last = (s == TAIL1);
            end
          end
        endcase
      end
    endcase
  end

  assign tx_valid = (mode == M_RUN) && !cur_skip;
  assign tx_ctrl  = CMD_TAG;
  assign tx_byte  = cur_byte;
  assign busy     = (mode != M_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= M_IDLE;
      kind      <= K_INIT;
      idx       <= '0;
      cnt       <= '0;
      bright_q  <= 8'd127;
      panel_rst <= 1'b0;
      done      <= 1'b0;
      lut_warn  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (mode)
        M_IDLE: begin
          idx <= '0;
          cnt <= '0;
          if (start) begin
            kind      <= K_INIT;
            mode      <= M_RST;
            panel_rst <= 1'b1;
            lut_warn  <= 1'b0;
          end else if (disp_off_req) begin
            kind <= K_OFF;
            mode <= M_RUN;
          end else if (disp_on_req) begin
            kind <= K_ON;
            mode <= M_RUN;
          end else if (bright_req) begin
            kind     <= K_BRIGHT;
            bright_q <= bright_val;
            mode     <= M_RUN;
          end
        end
        M_RST: begin
          if (cnt == CW'(RST_CYCLES - 1)) begin
            cnt       <= '0;
            panel_rst <= 1'b0;
            mode      <= M_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        M_WAIT: begin
          if (cnt == CW'(RST_CYCLES - 1)) begin
            cnt  <= '0;
            mode <= M_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (tx_valid && tx_ready && kind == K_INIT && in_lut &&
              (cur_byte < LUT_LO || cur_byte > LUT_HI))
            lut_warn <= 1'b1;
          if ((tx_valid && tx_ready) || cur_skip) begin
            if (cur_last) begin
              mode <= M_IDLE;
              done <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
      endcase
    end
  end

endmodule

module oled_init_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_byte,
  input logic       panel_rst,
  input logic       done,
  input logic       lut_warn
);

  assert_rst_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    panel_rst |-> !tx_valid);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  assert_warn_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_warn && !(start && !busy)) |=> lut_warn);

endmodule

bind oled_init_seq oled_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
  .panel_rst(panel_rst), .done(done), .lut_warn(lut_warn)
);

// File: tb/oled_init_seq_tb.sv
module oled_init_seq_tb;
  localparam int RST = 5;
  localparam int N   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, on_r = 0, off_r = 0, br_r = 0;
  logic [7:0] br_val = 0;
  logic [7:0] contrast, height, comoff, vcomh;
  logic [4:0] clkdiv;
  logic [3:0] freq, p1, p2;
  logic seg, inv, ac, lp, seq, lr, pump, lut_en;
  logic [8*N-1:0] lut;
  logic panel_rst, tx_valid, tx_ready, busy, done, lut_warn;
  logic [7:0] tx_ctrl, tx_byte;

  oled_init_seq #(.RST_CYCLES(RST), .LUT_ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .disp_on_req(on_r),
    .disp_off_req(off_r), .bright_req(br_r), .bright_val(br_val),
    .cfg_contrast(contrast), .cfg_height(height), .cfg_com_offset(comoff),
    .cfg_clk_div(clkdiv), .cfg_osc_freq(freq), .cfg_pre1(p1), .cfg_pre2(p2),
    .cfg_seg_remap(seg), .cfg_com_invert(inv), .cfg_area_color(ac),
    .cfg_low_power(lp), .cfg_com_seq(seq), .cfg_lr_remap(lr),
    .cfg_vcomh(vcomh), .cfg_pump_need(pump), .cfg_lut_en(lut_en),
    .cfg_lut(lut), .panel_rst(panel_rst), .tx_valid(tx_valid),
    .tx_ctrl(tx_ctrl), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .busy(busy), .done(done), .lut_warn(lut_warn)
  );

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  int rst_hi, gap, ctrl_bad, stall_bad, done_cnt;
  logic [7:0] cap[$];
  logic [7:0] exp_q[$];
  logic [15:0] lfsr = 16'hACE1;
  bit rand_ready = 0, wd_fired = 0;
  logic prev_stall = 0;
  logic [7:0] prev_byte = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always @(posedge clk) begin
    #1;
    tx_ready = rand_ready ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (panel_rst) rst_hi++;
    if (busy && !panel_rst && !tx_valid && cap.size() == 0 && rst_hi > 0) gap++;
    if (tx_valid && tx_ready) begin
      cap.push_back(tx_byte);
      if (tx_ctrl != 8'h80) ctrl_bad++;
    end
    if (prev_stall && (!tx_valid || tx_byte != prev_byte)) stall_bad++;
    prev_stall = tx_valid && !tx_ready;
    prev_byte  = tx_byte;
    if (done) done_cnt++;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !wd_fired) begin
      wd_fired = 1;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clear_mon;
    cap.delete();
    rst_hi = 0; gap = 0; ctrl_bad = 0; stall_bad = 0; done_cnt = 0;
  endtask

  task automatic fire(input bit s, input bit o, input bit n, input bit b);
    clear_mon();
    start = s; off_r = o; on_r = n; br_r = b;
    tick();
    start = 0; off_r = 0; on_r = 0; br_r = 0;
    while (done_cnt == 0) tick();
    repeat (6) tick();
  endtask

  task automatic build_init;
    exp_q.delete();
    exp_q.push_back(8'h81); exp_q.push_back(contrast);
    if (seg) exp_q.push_back(8'hA1);
    exp_q.push_back(inv ? 8'hC4 : 8'hC0);
    exp_q.push_back(8'hA8); exp_q.push_back(height - 8'd1);
    exp_q.push_back(8'hD3); exp_q.push_back(comoff);
    exp_q.push_back(8'hD5); exp_q.push_back({freq, 4'(clkdiv - 5'd1)});
    if (ac || lp) begin
      exp_q.push_back(8'hD8);
      exp_q.push_back((ac ? 8'h1E : 8'h00) | (lp ? 8'h05 : 8'h00));
    end
    exp_q.push_back(8'hD9); exp_q.push_back({p2, p1});
    exp_q.push_back(8'hDA);
    exp_q.push_back(8'h02 | (seq ? 8'h00 : 8'h10) | (lr ? 8'h20 : 8'h00));
    exp_q.push_back(8'hDB); exp_q.push_back(vcomh);
    exp_q.push_back(8'h8D); exp_q.push_back(pump ? 8'h14 : 8'h10);
    if (lut_en) begin
      exp_q.push_back(8'h91);
      for (int i = 0; i < N; i++) exp_q.push_back(lut[8*i +: 8]);
    end
    exp_q.push_back(8'h20); exp_q.push_back(8'h00);
  endtask

  task automatic cmp_seq(input string req);
    int mis = -1;
    chk(cap.size() == exp_q.size(), {req, " length"}, cap.size(), exp_q.size());
    for (int i = 0; i < cap.size() && i < exp_q.size(); i++)
      if (mis < 0 && cap[i] != exp_q[i]) mis = i;
    if (mis >= 0) chk(0, {req, " byte"}, cap[mis], exp_q[mis]);
    else chk(1, req, 0, 0);
  endtask

  task automatic t_reset;
    chk(!busy, "R9 reset busy", busy, 0);
    chk(!tx_valid, "R9 reset valid", tx_valid, 0);
    chk(!panel_rst, "R1 reset pin", panel_rst, 0);
    chk(!lut_warn && !done, "R6 reset warn", lut_warn, 0);
  endtask

  task automatic t_init_full;
    seg = 1; inv = 1; ac = 1; lp = 1; seq = 0; lr = 1; pump = 1; lut_en = 1;
    lut = {8'd31, 8'd63, 8'd20, 8'd40};
    rand_ready = 0;
    build_init();
    fire(1, 0, 0, 0);
    cmp_seq("R3 full script");
    chk(rst_hi == RST, "R1 reset high", rst_hi, RST);
    chk(gap == RST, "R1 reset wait", gap, RST);
    chk(ctrl_bad == 0, "R2 control tag", ctrl_bad, 0);
    chk(cap.size() > 9 && cap[3] == 8'hC4, "R5 scan byte", cap[3], 8'hC4);
    chk(cap.size() > 11 && cap[11] == 8'h1F, "R5 mode byte", cap[11], 8'h1F);
    chk(done_cnt == 1 && !busy, "R9 done pulse", done_cnt, 1);
    chk(lut_warn, "R6 warn set", lut_warn, 1);
  endtask

  task automatic t_init_min;
    seg = 0; inv = 0; ac = 0; lp = 0; seq = 1; lr = 0; pump = 0; lut_en = 0;
    rand_ready = 1;
    build_init();
    fire(1, 0, 0, 0);
    cmp_seq("R4 trimmed script");
    chk(cap.size() == 19, "R4 trimmed length", cap.size(), 19);
    chk(stall_bad == 0, "R10 stall hold", stall_bad, 0);
    chk(!lut_warn, "R6 warn cleared", lut_warn, 1'b0);
    chk(ctrl_bad == 0, "R2 control tag", ctrl_bad, 0);
  endtask

  task automatic t_init_lp;
    seg = 1; ac = 0; lp = 1; lut_en = 1; clkdiv = 5'd16; freq = 4'hF;
    lut = {8'd50, 8'd45, 8'd63, 8'd31};
    rand_ready = 1;
    build_init();
    fire(1, 0, 0, 0);
    cmp_seq("R5 low-power script");
    chk(!lut_warn, "R6 in-range entries", lut_warn, 0);
    chk(stall_bad == 0, "R10 stall hold", stall_bad, 0);
    clkdiv = 5'd1; freq = 4'h8;
  endtask

  task automatic t_onoff;
    rand_ready = 0;
    exp_q.delete(); exp_q.push_back(8'hAF);
    fire(0, 0, 1, 0);
    cmp_seq("R7 display on");
    chk(rst_hi == 0, "R7 no reset pulse", rst_hi, 0);
    exp_q.delete(); exp_q.push_back(8'hAE);
    fire(0, 1, 0, 0);
    cmp_seq("R7 display off");
  endtask

  task automatic t_bright;
    clear_mon();
    rand_ready = 1;
    br_val = 8'd200; br_r = 1;
    tick();
    br_r = 0; br_val = 8'd9;
    while (done_cnt == 0) tick();
    repeat (4) tick();
    exp_q.delete(); exp_q.push_back(8'h81); exp_q.push_back(8'd200);
    cmp_seq("R8 brightness");
  endtask

  task automatic t_busy_ignore;
    lut_en = 0; rand_ready = 0;
    build_init();
    clear_mon();
    start = 1; tick(); start = 0;
    repeat (2 * RST + 3) tick();
    on_r = 1; br_r = 1; tick(); on_r = 0; br_r = 0;
    while (done_cnt == 0) tick();
    repeat (8) tick();
    cmp_seq("R9 requests while busy ignored");
  endtask

  task automatic t_priority;
    rand_ready = 0; lut_en = 0;
    build_init();
    fire(1, 1, 0, 0);
    cmp_seq("R11 start over off");
    exp_q.delete(); exp_q.push_back(8'hAE);
    fire(0, 1, 1, 0);
    cmp_seq("R11 off over on");
    exp_q.delete(); exp_q.push_back(8'hAF);
    fire(0, 0, 1, 1);
    cmp_seq("R11 on over brightness");
  endtask

  initial begin
    contrast = 8'd127; height = 8'd64; comoff = 8'd3; vcomh = 8'h40;
    clkdiv = 5'd2; freq = 4'h8; p1 = 4'd2; p2 = 4'd2;
    seg = 0; inv = 0; ac = 0; lp = 0; seq = 0; lr = 0; pump = 0; lut_en = 0;
    lut = '0;
    clear_mon();
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_init_full();
    t_init_min();
    t_init_lp();
    t_onoff();
    t_bright();
    t_busy_ignore();
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule